// File: doc/BRIEF.md
# Postscaled Watchdog Timer

This block is a watchdog that runs from its own slow clock. It is separate from the processor clock. A fixed prescaler divides the slow clock down to a base tick. A power-of-two postscaler then counts base ticks. A 4-bit select field chooses the postscaler tap, and the timeout expires on that tap. When the timeout expires, the block sends a one-cycle pulse. The pulse goes to the reset output if the core is awake and to the wake-up output if the core is asleep.

The processor side controls the block with several inputs:

- two enables: a hardware configuration bit and a software bit;
- three clear strobes: clear-watchdog, sleep entry, and change of clock setting;
- a clock-failure level flag.

All control inputs are crossed into the watchdog clock domain. The strobes cross through a request/acknowledge handshake, so a short strobe is never lost. The level inputs cross through multi-flop synchronizers. Whenever a clear is active or the watchdog is disabled, the prescaler and postscaler are held at zero. A clear takes priority over counting in the watchdog cycle in which it is seen. The oscillator-request output tells the clock source to run whenever the watchdog is enabled.

Top module: `wdt_postscaled`

## Requirements
- R1: `osc_req` is high exactly when `hw_en` or `sw_en` is high. The path is combinational.
- R2: The watchdog runs when at least one of `hw_en` and `sw_en` is high. When both are low, no timeout pulse is produced.
- R3: With `ps_sel` held at value k (0 to 15), the timeout period is `BASE_DIV * 2^k` watchdog clock cycles.
- R4: A one-cycle `clr_wdt` strobe restarts the count. The next timeout pulse appears no sooner than one full period after the strobe, plus the synchronizer latency of up to 10 watchdog cycles.
- R5: A `sleep_enter` strobe restarts the count in the same way as R4.
- R6: A `clk_sel_chg` strobe restarts the count in the same way as R4.
- R7: While `clk_fail` is high, the counts stay cleared and no timeout occurs. After `clk_fail` falls, a full period is counted again.
- R8: A timeout while `core_asleep` is low gives a one-cycle pulse on `wdt_rst`. A timeout while `core_asleep` is high gives a one-cycle pulse on `wdt_wake`. The two outputs are never high together.
- R9: After each pulse the count restarts from zero, so consecutive pulses under a fixed setting are spaced exactly one period apart.
- R10: While `rst_n` is low, both outputs are low and all counts are cleared. The first timeout after release comes at least one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock; samples the strobes |
| wdt_clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| hw_en | input | 1 | Configuration enable |
| sw_en | input | 1 | Software enable |
| ps_sel | input | SEL_W | Postscaler tap select; value k divides the base tick by 2^k |
| clr_wdt | input | 1 | Clear-watchdog strobe (cpu_clk domain) |
| sleep_enter | input | 1 | Sleep-entry strobe (cpu_clk domain) |
| clk_sel_chg | input | 1 | Clock-setting-change strobe (cpu_clk domain) |
| clk_fail | input | 1 | Clock-failure level flag |
| core_asleep | input | 1 | High while the core is in sleep |
| osc_req | output | 1 | Request that the slow oscillator run |
| wdt_rst | output | 1 | Device-reset pulse (wdt_clk domain) |
| wdt_wake | output | 1 | Wake-up pulse (wdt_clk domain) |

## Verification
The assertions assume the following about the inputs:

- `ps_sel`, `core_asleep` and the enables are quasi-static, so their synchronized copies settle before they matter.
- `BASE_DIV` is at least 2, so two expiries can never fall on adjacent cycles.

The bench keeps to these assumptions. It changes every level input on the processor clock and then waits several periods before it measures any pulse spacing. It gives each strobe a gap of many watchdog cycles. It judges clear and reset latency against windows that include the synchronizer delay, not against an exact cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int WDT_SYNC_MIN = 2;

   typedef struct packed {
      logic run;
      logic asleep;
      logic fail;
   } wdt_ctl_t;

   localparam int WDT_CTL_W = $bits(wdt_ctl_t);

   function automatic int tap_count(input int sel_w);
      return 1 << sel_w;
   endfunction

endpackage

// File: rtl/wdt_sync_level.sv
module wdt_sync_level #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[i] <= '0;
               else        stage_q[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[i] <= '0;
               else        stage_q[i] <= stage_q[i-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wdt_clr_handshake.sv
module wdt_clr_handshake #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic strobe,
   output logic clr_level
);
   logic req_q;
   logic ack_s;

   // request stays up until the destination has been seen to hold it
   always_ff @(posedge src_clk or negedge rst_n)
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= (req_q & ~ack_s) | strobe;

   wdt_sync_level #(.W(1), .STAGES(STAGES)) u_fwd (
      .clk (dst_clk), .rst_n (rst_n), .d (req_q), .q (clr_level)
   );

   wdt_sync_level #(.W(1), .STAGES(STAGES)) u_back (
      .clk (src_clk), .rst_n (rst_n), .d (clr_level), .q (ack_s)
   );

   // R4: a strobe is captured on the next source edge whatever the ack state
   a_r4_strobe_latched: assert property (@(posedge src_clk) disable iff (!rst_n)
      strobe |=> req_q);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int BASE_DIV = 128,
   parameter int SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int TAPS   = wdt_pkg::tap_count(SEL_W);
   localparam int POST_W = TAPS - 1;
   localparam int PRE_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_DIV - 1);

   logic [PRE_W-1:0]  pre_q;
   logic [POST_W-1:0] post_q;
   logic [TAPS-1:0]   tap_hit;
   logic              base_tick;

   genvar k;
   generate
      for (k = 0; k < TAPS; k++) begin : g_tap
         if (k == 0) begin : g_div1
            assign tap_hit[k] = 1'b1;
         end else begin : g_divn
            assign tap_hit[k] = &post_q[k-1:0];
         end
      end
   endgenerate

   assign base_tick = (pre_q == PRE_LAST);
   assign expire    = run & ~clr & base_tick & tap_hit[sel];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pre_q  <= '0;
         post_q <= '0;
      end else if (!run || clr || expire) begin
         pre_q  <= '0;
         post_q <= '0;
      end else if (base_tick) begin
         pre_q  <= '0;
         post_q <= post_q + 1'b1;
      end else begin
         pre_q  <= pre_q + 1'b1;
      end

   a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PRE_LAST);
   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0 && post_q == '0));
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (pre_q == '0 && post_q == '0));
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0 && post_q == '0));
endmodule

// File: rtl/wdt_route.sv
module wdt_route (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic asleep,
   output logic rst_p,
   output logic wake_p
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rst_p  <= 1'b0;
         wake_p <= 1'b0;
      end else begin
         rst_p  <= expire & ~asleep;
         wake_p <= expire & asleep;
      end

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_p, wake_p}));
   a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_p |=> !rst_p);
   a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_p |=> !wake_p);
endmodule

// File: rtl/wdt_postscaled.sv
module wdt_postscaled #(
   parameter int BASE_DIV    = 128,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             cpu_clk,
   input  logic             wdt_clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_en,
   input  logic [SEL_W-1:0] ps_sel,
   input  logic             clr_wdt,
   input  logic             sleep_enter,
   input  logic             clk_sel_chg,
   input  logic             clk_fail,
   input  logic             core_asleep,
   output logic             osc_req,
   output logic             wdt_rst,
   output logic             wdt_wake
);
   import wdt_pkg::*;

   localparam int LVL_W = WDT_CTL_W + SEL_W;

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("wdt_postscaled: BASE_DIV must be at least 2");
      end
      if (SYNC_STAGES < WDT_SYNC_MIN) begin : g_bad_sync
         $error("wdt_postscaled: SYNC_STAGES below minimum");
      end
      if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
         $error("wdt_postscaled: SEL_W must lie in 1..5");
      end
   endgenerate

   wdt_ctl_t         ctl_raw, ctl_s;
   logic [SEL_W-1:0] sel_s;
   logic             clr_any_cpu;
   logic             clr_hs;
   logic             clr_all;
   logic             expire;

   assign osc_req     = hw_en | sw_en;
   assign clr_any_cpu = clr_wdt | sleep_enter | clk_sel_chg;

   always_comb begin
      ctl_raw.run    = hw_en | sw_en;
      ctl_raw.asleep = core_asleep;
      ctl_raw.fail   = clk_fail;
   end

   wdt_sync_level #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_lvl (
      .clk   (wdt_clk),
      .rst_n (rst_n),
      .d     ({ctl_raw, ps_sel}),
      .q     ({ctl_s, sel_s})
   );

   wdt_clr_handshake #(.STAGES(SYNC_STAGES)) u_clr (
      .src_clk   (cpu_clk),
      .dst_clk   (wdt_clk),
      .rst_n     (rst_n),
      .strobe    (clr_any_cpu),
      .clr_level (clr_hs)
   );

   assign clr_all = clr_hs | ctl_s.fail;

   wdt_count #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_cnt (
      .clk    (wdt_clk),
      .rst_n  (rst_n),
      .run    (ctl_s.run),
      .clr    (clr_all),
      .sel    (sel_s),
      .expire (expire)
   );

   wdt_route u_route (
      .clk    (wdt_clk),
      .rst_n  (rst_n),
      .expire (expire),
      .asleep (ctl_s.asleep),
      .rst_p  (wdt_rst),
      .wake_p (wdt_wake)
   );

   // R2: a disabled watchdog produces nothing on the following cycle
   a_r2_off_quiet: assert property (@(posedge wdt_clk) disable iff (!rst_n)
      !ctl_s.run |=> !(wdt_rst || wdt_wake));
   // R7: a held failure flag suppresses timeouts
   a_r7_fail_quiet: assert property (@(posedge wdt_clk) disable iff (!rst_n)
      ctl_s.fail |=> !(wdt_rst || wdt_wake));
endmodule

// File: tb/wdt_postscaled_tb.sv
module wdt_postscaled_tb;
   localparam int DIV = 2;
   localparam int SW  = 4;

   logic cpu_clk = 1'b0;
   logic wdt_clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_en = 1'b0, sw_en = 1'b0;
   logic [SW-1:0] ps_sel = '0;
   logic clr_wdt = 1'b0, sleep_enter = 1'b0, clk_sel_chg = 1'b0;
   logic clk_fail = 1'b0, core_asleep = 1'b0;
   logic osc_req, wdt_rst, wdt_wake;

   int checks = 0, errors = 0;
   int cyc = 0, last_pulse = 0, gap_last = 0, gap_prev = 0;
   int n_rst = 0, n_wake = 0, width_err = 0, both_err = 0;
   logic prev_rst = 1'b0, prev_wake = 1'b0;

   always #2 cpu_clk = ~cpu_clk;
   initial begin
      #1;
      forever #16 wdt_clk = ~wdt_clk;
   end

   wdt_postscaled #(.BASE_DIV(DIV), .SEL_W(SW), .SYNC_STAGES(2)) u_dut (
      .cpu_clk(cpu_clk), .wdt_clk(wdt_clk), .rst_n(rst_n),
      .hw_en(hw_en), .sw_en(sw_en), .ps_sel(ps_sel),
      .clr_wdt(clr_wdt), .sleep_enter(sleep_enter), .clk_sel_chg(clk_sel_chg),
      .clk_fail(clk_fail), .core_asleep(core_asleep),
      .osc_req(osc_req), .wdt_rst(wdt_rst), .wdt_wake(wdt_wake)
   );

   always @(negedge wdt_clk) begin
      cyc = cyc + 1;
      if (wdt_rst && wdt_wake) both_err = both_err + 1;
      if ((wdt_rst && prev_rst) || (wdt_wake && prev_wake)) width_err = width_err + 1;
      if (wdt_rst)  n_rst  = n_rst + 1;
      if (wdt_wake) n_wake = n_wake + 1;
      if (wdt_rst || wdt_wake) begin
         gap_prev   = gap_last;
         gap_last   = cyc - last_pulse;
         last_pulse = cyc;
      end
      prev_rst  = wdt_rst;
      prev_wake = wdt_wake;
   end

   function automatic int period(input int sel);
      return DIV << sel;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wdt_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge wdt_clk);
   endtask

   task automatic wait_pulses(input int n, input int limit);
      int target;
      int stop;
      target = n_rst + n_wake + n;
      stop   = cyc + limit;
      while ((n_rst + n_wake) < target && cyc < stop) @(negedge wdt_clk);
   endtask

   task automatic t_reset;
      wdt_wait(3);
      chk(wdt_rst == 1'b0 && wdt_wake == 1'b0, "R10", "outputs in reset",
          {wdt_rst, wdt_wake}, 0);
      chk(osc_req == 1'b0, "R1", "osc_req idle", osc_req, 0);
      @(negedge cpu_clk) rst_n = 1'b1;
   endtask

   task automatic t_osc;
      for (int v = 0; v < 4; v++) begin
         @(negedge cpu_clk) {hw_en, sw_en} = v[1:0];
         #1 chk(osc_req == (v != 0), "R1", "osc_req", osc_req, int'(v != 0));
      end
      @(negedge cpu_clk) {hw_en, sw_en} = 2'b00;
   endtask

   task automatic t_disabled;
      int base;
      ps_sel = 4'd0;
      wdt_wait(4);
      base = n_rst + n_wake;
      wdt_wait(400);
      chk((n_rst + n_wake) == base, "R2", "pulses while disabled",
          n_rst + n_wake - base, 0);
   endtask

   task automatic t_enable_each;
      int base;
      @(negedge cpu_clk) begin hw_en = 1'b1; sw_en = 1'b0; ps_sel = 4'd2; end
      base = n_rst;
      wdt_wait(60);
      chk(n_rst > base, "R2", "hw_en alone pulses", n_rst - base, 1);
      @(negedge cpu_clk) begin hw_en = 1'b0; sw_en = 1'b1; end
      wdt_wait(6);
      base = n_rst;
      wdt_wait(60);
      chk(n_rst > base, "R2", "sw_en alone pulses", n_rst - base, 1);
   endtask

   task automatic t_period(input int sel);
      @(negedge cpu_clk) ps_sel = SW'(sel);
      wait_pulses(4, 5 * period(sel) + 20);
      chk(gap_last == period(sel), "R3", $sformatf("period sel=%0d", sel),
          gap_last, period(sel));
      chk(gap_prev == gap_last, "R9", $sformatf("restart spacing sel=%0d", sel),
          gap_prev, gap_last);
   endtask

   task automatic strobe(input int which);
      @(negedge cpu_clk);
      case (which)
         0: clr_wdt = 1'b1;
         1: sleep_enter = 1'b1;
         default: clk_sel_chg = 1'b1;
      endcase
      @(negedge cpu_clk);
      clr_wdt = 1'b0; sleep_enter = 1'b0; clk_sel_chg = 1'b0;
   endtask

   task automatic t_clear(input int which, input string req);
      int base;
      int mark;
      int d;
      @(negedge cpu_clk) ps_sel = 4'd4;
      wait_pulses(2, 200);
      base = n_rst + n_wake;
      for (int i = 0; i < 30; i++) begin
         strobe(which);
         for (int j = 0; j < 62; j++) @(negedge cpu_clk);
      end
      chk((n_rst + n_wake) == base, req, "pulses under repeated clear",
          n_rst + n_wake - base, 0);
      strobe(which);
      mark = cyc;
      wait_pulses(1, period(4) + 30);
      d = last_pulse - mark;
      chk(d >= period(4) && d <= period(4) + 10, req, "delay after last clear",
          d, period(4));
   endtask

   task automatic t_fail;
      int base;
      int mark;
      int d;
      @(negedge cpu_clk) clk_fail = 1'b1;
      wdt_wait(4);
      base = n_rst + n_wake;
      wdt_wait(200);
      chk((n_rst + n_wake) == base, "R7", "pulses during clock failure",
          n_rst + n_wake - base, 0);
      @(negedge cpu_clk) clk_fail = 1'b0;
      mark = cyc;
      wait_pulses(1, period(4) + 30);
      d = last_pulse - mark;
      chk(d >= period(4) && d <= period(4) + 10, "R7", "delay after failure clears",
          d, period(4));
   endtask

   task automatic t_sleep;
      int br;
      int bw;
      @(negedge cpu_clk) begin core_asleep = 1'b1; ps_sel = 4'd1; end
      wdt_wait(8);
      br = n_rst; bw = n_wake;
      wdt_wait(60);
      chk(n_wake > bw, "R8", "wake pulses while asleep", n_wake - bw, 1);
      chk(n_rst == br, "R8", "no reset while asleep", n_rst - br, 0);
      @(negedge cpu_clk) core_asleep = 1'b0;
      wdt_wait(8);
      br = n_rst; bw = n_wake;
      wdt_wait(60);
      chk(n_rst > br, "R8", "reset pulses while awake", n_rst - br, 1);
      chk(n_wake == bw, "R8", "no wake while awake", n_wake - bw, 0);
      chk(width_err == 0, "R8", "pulse width one cycle", width_err, 0);
      chk(both_err == 0, "R8", "outputs exclusive", both_err, 0);
   endtask

   task automatic t_reset_mid;
      int base;
      int mark;
      int d;
      @(negedge cpu_clk) ps_sel = 4'd3;
      wait_pulses(1, 100);
      wdt_wait(9);
      @(negedge cpu_clk) rst_n = 1'b0;
      base = n_rst + n_wake;
      wdt_wait(40);
      chk((n_rst + n_wake) == base && !wdt_rst && !wdt_wake, "R10",
          "quiet during reset", n_rst + n_wake - base, 0);
      @(negedge cpu_clk) rst_n = 1'b1;
      mark = cyc;
      wait_pulses(1, period(3) + 30);
      d = last_pulse - mark;
      chk(d >= period(3) && d <= period(3) + 8, "R10", "first timeout after reset",
          d, period(3));
   endtask

   initial begin
      #700us;
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_osc();
      t_disabled();
      t_enable_each();
      t_period(0);
      t_period(3);
      t_period(9);
      t_clear(0, "R4");
      t_clear(1, "R5");
      t_clear(2, "R6");
      t_fail();
      t_sleep();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule